// File: doc/BRIEF.md
# Decimating Multiply-Accumulate Filter Cell Array

This block holds eight filter cells that each multiply a data sample by a coefficient and add the 18-bit signed product into a private 26-bit accumulator on every clock. One data word is broadcast to all cells at once. Coefficients are shifted in at cell 0 and march toward cell 7. After each cell the coefficient passes through zero to three extra delay registers, chosen by a decimation select. The tail of the chain leaves the block on a coefficient output. That output can be looped back to the coefficient input, or fed to a second array.

The accumulators are read through an address port. A downstream output stage chooses one cell and sees its value combinationally. A two-bit clear code chooses what is wiped on the next edge: everything, only the addressed accumulator, only the registers, or nothing. Operands are 9-bit two's complement. An 8-bit unsigned operand is handled by holding its top bit at zero.

Both input streams are qualified by a valid strobe. The array accepts a word on every cycle its strobe is high and never applies back-pressure, so it has no ready output. The clear code, decimation select, address and output gate are plain level controls.

Top module: `fir_cell_array`

## Requirements
- R1: When `din_vld` is high and the clear code is 11 or 01, every cell's data register takes `din` at the next rising edge. When `din_vld` is low, the data registers hold.
- R2: When `cin_vld` is high, the coefficient chain advances one position. Cell 0 takes `cin`, and each later cell takes the value leaving the previous cell's delay section. When `cin_vld` is low, the whole chain holds.
- R3: `dec_sel` = 00, 01, 10 or 11 places 0, 1, 2 or 3 delay registers after every cell, including cell 7. A coefficient applied at `cin` therefore first appears at `cout` after 8×(1+`dec_sel`) advances.
- R4: `cout` shows the tail of cell 7's delay section while `cout_en` is 1, and reads zero while `cout_en` is 0.
- R5: On each edge where it is not cleared, a cell's accumulator adds the sign-extended 18-bit product of its data and coefficient registers, modulo 2^26.
- R6: Clear code 00 zeroes all accumulators, all data registers, all coefficient registers and all delay registers at the next edge.
- R7: Clear code 01 zeroes only the accumulator addressed by `acc_sel`. The other accumulators still add their products, and the registers still load and shift.
- R8: Clear code 10 zeroes all data, coefficient and delay registers. The accumulators are not cleared and add their product for that cycle.
- R9: Clear code 11 clears nothing. After reset, with no loads, every accumulator and `cout` read zero.
- R10: A clear takes priority over a load or shift in the same cycle: registers that are being cleared end at zero even if `din_vld` or `cin_vld` is high.
- R11: `acc_out` equals the current accumulator of the cell whose index is on `acc_sel`, with no register delay.
- R12: Operands multiply as 9-bit two's complement. 255×200 adds 51000, and (−256)×(−256) adds 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| din | input | 9 | Data sample, broadcast to all cells |
| din_vld | input | 1 | Data strobe; loads `din` into every cell |
| cin | input | 9 | Coefficient into cell 0 |
| cin_vld | input | 1 | Coefficient strobe; advances the whole chain |
| dec_sel | input | 2 | Number of delay registers after each cell (0 to 3) |
| clr_code | input | 2 | 00 all, 01 addressed accumulator, 10 registers, 11 none |
| acc_sel | input | 3 | Cell index for readout and for the single clear |
| cout_en | input | 1 | Enables the coefficient output |
| acc_out | output | 26 | Addressed accumulator |
| cout | output | 9 | Coefficient leaving the chain, or zero |

## Verification
Two functions can land on the same edge: a clear, and the loading, shifting or accumulation it must either override or leave alone. The bench provokes this with a seeded random stream that often pairs clear codes 01, 10 and 00 with raised strobes and changing addresses and decimation settings. Every cycle, it compares the addressed accumulator and the coefficient output with a reference model written from the requirements. Directed cases pin the chain latency for two decimation settings and check the signed and unsigned product corners with literal values.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [1:0] {
    CLR_ALL  = 2'b00,
    CLR_ONE  = 2'b01,
    CLR_REGS = 2'b10,
    CLR_NONE = 2'b11
  } clr_code_e;
endpackage

// File: rtl/fir_coef_stage.sv
module fir_coef_stage #(
  parameter int DW      = 9,
  parameter int DEC_MAX = 3,
  parameter int SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             clr,
  input  logic [SEL_W-1:0] dec_sel,
  input  logic [DW-1:0]    c_in,
  output logic [DW-1:0]    c_q,
  output logic [DW-1:0]    c_next
);
  logic [DW-1:0] dly [DEC_MAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= '0;
      for (int k = 0; k < DEC_MAX; k++) dly[k] <= '0;
    end else if (clr) begin
      c_q <= '0;
      for (int k = 0; k < DEC_MAX; k++) dly[k] <= '0;
    end else if (shift) begin
      c_q    <= c_in;
      dly[0] <= c_q;
      for (int k = 1; k < DEC_MAX; k++) dly[k] <= dly[k-1];
    end
  end

  // tap chosen by the decimation select
  always_comb begin
    c_next = c_q;
    for (int k = 0; k < DEC_MAX; k++)
      if (dec_sel == SEL_W'(k + 1)) c_next = dly[k];
  end

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr) |=> (c_q == $past(c_in)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !clr) |=> $stable(c_q));
  p_dly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr) |=> (dly[0] == $past(c_q)));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (c_q == '0 && dly[0] == '0));
endmodule

// File: rtl/fir_mac_cell.sv
module fir_mac_cell #(
  parameter int DW = 9,
  parameter int AW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] c,
  input  logic          clr_regs,
  input  logic          clr_acc,
  output logic [AW-1:0] acc_q
);
  localparam int PW = 2 * DW;

  logic [DW-1:0]        x_q;
  logic signed [PW-1:0] prod;
  logic [AW-1:0]        prod_ext;

  assign prod     = $signed(x_q) * $signed(c);
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        x_q <= '0;
    else if (clr_regs) x_q <= '0;
    else if (ld)       x_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (clr_acc) acc_q <= '0;
    else              acc_q <= acc_q + prod_ext;
  end

  p_load_x_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr_regs) |=> (x_q == $past(din)));
  p_x_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !clr_regs) |=> $stable(x_q));
  p_clr_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> (acc_q == '0));
  p_clr_x_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_regs |=> (x_q == '0));
endmodule

// File: rtl/fir_cell_array.sv
module fir_cell_array #(
  parameter int N_CELLS = 8,
  parameter int DW      = 9,
  parameter int AW      = 26,
  parameter int DEC_MAX = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DW-1:0]                din,
  input  logic                         din_vld,
  input  logic [DW-1:0]                cin,
  input  logic                         cin_vld,
  input  logic [$clog2(DEC_MAX+1)-1:0] dec_sel,
  input  logic [1:0]                   clr_code,
  input  logic [$clog2(N_CELLS)-1:0]   acc_sel,
  input  logic                         cout_en,
  output logic [AW-1:0]                acc_out,
  output logic [DW-1:0]                cout
);
  import fir_pkg::*;
  localparam int SEL_W  = $clog2(DEC_MAX + 1);
  localparam int ADDR_W = $clog2(N_CELLS);

  clr_code_e     code;
  logic          clr_regs;
  logic [DW-1:0] c_cell [N_CELLS];
  logic [DW-1:0] c_link [N_CELLS];
  logic [AW-1:0] acc_all [N_CELLS];

  assign code     = clr_code_e'(clr_code);
  assign clr_regs = (code == CLR_ALL) || (code == CLR_REGS);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic [DW-1:0] c_src;
    logic          clr_acc;
    if (i == 0) begin : g_head
      assign c_src = cin;
    end else begin : g_body
      assign c_src = c_link[i-1];
    end
    assign clr_acc = (code == CLR_ALL) ||
                     ((code == CLR_ONE) && (acc_sel == ADDR_W'(i)));

    fir_coef_stage #(.DW(DW), .DEC_MAX(DEC_MAX), .SEL_W(SEL_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .shift(cin_vld), .clr(clr_regs),
      .dec_sel(dec_sel), .c_in(c_src), .c_q(c_cell[i]), .c_next(c_link[i]));

    fir_mac_cell #(.DW(DW), .AW(AW)) u_mac (
      .clk(clk), .rst_n(rst_n), .ld(din_vld), .din(din), .c(c_cell[i]),
      .clr_regs(clr_regs), .clr_acc(clr_acc), .acc_q(acc_all[i]));
  end

  assign acc_out = acc_all[acc_sel];
  assign cout    = cout_en ? c_link[N_CELLS-1] : '0;

  p_cout_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cout_en |-> (cout == '0));
  p_sel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_code == 2'b01) ##1 $stable(acc_sel) |-> (acc_out == '0));
  p_all_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_code == 2'b00) |=> (acc_out == '0 && cout == '0));
endmodule

// File: tb/fir_cell_array_bench.sv
module fir_cell_array_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  din = '0, cin = '0;
  logic        din_vld = 1'b0, cin_vld = 1'b0, cout_en = 1'b1;
  logic [1:0]  dec_sel = '0, clr_code = 2'b11;
  logic [2:0]  acc_sel = '0;
  logic [25:0] acc_out;
  logic [8:0]  cout;

  // staged stimulus, applied at the next falling edge
  logic [8:0] n_din = '0, n_cin = '0;
  logic       n_dvld = 1'b0, n_cvld = 1'b0, n_oen = 1'b1;
  logic [1:0] n_dec = '0, n_code = 2'b11;
  logic [2:0] n_sel = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [25:0] seen_acc;
  logic [8:0]  seen_cout;

  // reference model state
  logic [8:0]  mx [8];
  logic [8:0]  mc [8];
  logic [8:0]  md [8][3];
  logic [25:0] ma [8];

  always #5 clk = ~clk;

  fir_cell_array u_fir_cell_array (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .cin(cin),
    .cin_vld(cin_vld), .dec_sel(dec_sel), .clr_code(clr_code),
    .acc_sel(acc_sel), .cout_en(cout_en), .acc_out(acc_out), .cout(cout));

  function automatic logic [25:0] mac(input logic [25:0] a, input logic [8:0] x,
                                      input logic [8:0] c);
    logic signed [17:0] p;
    logic signed [25:0] e;
    p = $signed(x) * $signed(c);
    e = p;
    return a + e;
  endfunction

  function automatic logic [8:0] tap(input int i, input logic [1:0] d);
    return (d == 2'd0) ? mc[i] : md[i][d-1];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      mx[i] = '0; mc[i] = '0; ma[i] = '0;
      for (int k = 0; k < 3; k++) md[i][k] = '0;
    end
  endtask

  task automatic model_update();
    logic [8:0]  t [8];
    logic        cr;
    for (int i = 0; i < 8; i++) t[i] = tap(i, dec_sel);
    for (int i = 0; i < 8; i++)
      ma[i] = (clr_code == 2'b00 || (clr_code == 2'b01 && acc_sel == 3'(i)))
              ? 26'd0 : mac(ma[i], mx[i], mc[i]);
    cr = (clr_code == 2'b00) || (clr_code == 2'b10);
    for (int i = 0; i < 8; i++) begin
      if (cr) begin
        mx[i] = '0; mc[i] = '0;
        for (int k = 0; k < 3; k++) md[i][k] = '0;
      end else begin
        if (din_vld) mx[i] = din;
        if (cin_vld) begin
          md[i][2] = md[i][1]; md[i][1] = md[i][0]; md[i][0] = mc[i];
          mc[i] = (i == 0) ? cin : t[i-1];
        end
      end
    end
  endtask

  // one cycle: apply staged inputs, compare outputs, advance the model
  task automatic step(input string tag);
    @(negedge clk);
    din = n_din; din_vld = n_dvld; cin = n_cin; cin_vld = n_cvld;
    dec_sel = n_dec; clr_code = n_code; acc_sel = n_sel; cout_en = n_oen;
    #1;
    seen_acc = acc_out; seen_cout = cout;
    chk({tag, " R11 acc_out"}, 32'(acc_out), 32'(ma[acc_sel]));
    chk({tag, " R4 cout"}, 32'(cout), 32'(cout_en ? tap(7, dec_sel) : 9'd0));
    model_update();
  endtask

  task automatic quiet();
    n_dvld = 1'b0; n_cvld = 1'b0; n_code = 2'b11;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    int first;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: reset state read through every address
    for (int a = 0; a < 8; a++) begin
      quiet(); n_sel = 3'(a);
      step("R9 reset");
      chk("R9 reset acc zero", 32'(seen_acc), 32'd0);
    end

    // R12: unsigned 255*200, then signed -256*-256
    n_code = 2'b00; step("R6 clear");
    quiet(); n_dec = 2'd0; n_sel = 3'd0;
    n_din = 9'd255; n_dvld = 1'b1; n_cin = 9'd200; n_cvld = 1'b1;
    step("R1 load");
    quiet(); step("R5 first product");
    step("R12 unsigned");
    chk("R12 unsigned 255x200", 32'(seen_acc), 32'd51000);
    n_code = 2'b00; step("R6 clear");
    quiet(); n_din = 9'h100; n_dvld = 1'b1; n_cin = 9'h100; n_cvld = 1'b1;
    step("R1 load");
    quiet(); step("R5 first product");
    step("R12 signed");
    chk("R12 signed -256x-256", 32'(seen_acc), 32'd65536);

    // R3: chain latency for decimation 0 and 2
    for (int d = 0; d < 3; d += 2) begin
      n_code = 2'b00; step("R6 clear");
      quiet(); n_dec = 2'(d); n_oen = 1'b1;
      n_cin = 9'h055; n_cvld = 1'b1;
      first = -1;
      for (int n = 1; n <= 30; n++) begin
        step("R3 latency");
        n_cin = 9'h000;
        if (first < 0 && seen_cout == 9'h055) first = n - 1;
      end
      chk("R3 advances to cout", 32'(first), 32'(8 * (1 + d)));
    end

    // R10: clears override strobes in the same cycle
    n_din = 9'h1AB; n_dvld = 1'b1; n_cin = 9'h0F3; n_cvld = 1'b1; n_code = 2'b11;
    repeat (12) step("R2 fill");
    n_code = 2'b10; step("R10 R8 reg clear with strobes");
    quiet(); n_sel = 3'd3; step("R8 acc kept");
    step("R8 acc frozen");
    n_code = 2'b00; n_dvld = 1'b1; n_cvld = 1'b1; step("R10 R6 full clear with strobes");
    quiet(); n_oen = 1'b1;
    step("R6 after clear");
    chk("R6 cout zero", 32'(seen_cout), 32'd0);

    // R7: addressed clear among loaded cells
    n_din = 9'h011; n_dvld = 1'b1; n_cin = 9'h1F7; n_cvld = 1'b1;
    repeat (10) step("R2 fill");
    quiet(); n_code = 2'b01; n_sel = 3'd5; step("R7 addressed clear");
    quiet(); step("R7 cleared cell");
    chk("R7 addressed acc zero", 32'(seen_acc), 32'd0);
    n_sel = 3'd4; step("R7 neighbour kept");

    // random mix (R1 R2 R5 R7 R8 R10 R11)
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(99));
      n_code = (r < 3) ? 2'b00 : (r < 10) ? 2'b01 : (r < 16) ? 2'b10 : 2'b11;
      n_din  = ($urandom_range(3) == 0) ? 9'($urandom_range(255)) : 9'($urandom);
      n_cin  = 9'($urandom);
      n_dvld = 1'($urandom);
      n_cvld = ($urandom_range(3) != 0);
      n_sel  = 3'($urandom);
      n_oen  = ($urandom_range(7) != 0);
      if ($urandom_range(49) == 0) n_dec = 2'($urandom);
      step("R5 R7 R8 random");
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule